// File: doc/BRIEF.md
# In-Place Sobel Frame Engine

This block sweeps a square-gridded grayscale frame that sits in one single-port pixel RAM. It applies the 3×3 Sobel operator to every window whose top-left corner lies inside the frame, less the last two columns and the last two rows. Each result is written back into the same RAM at the window's top-left pixel. Windows are visited left to right and then top to bottom. Every window therefore reads only pixels at or after its own corner in raster order, while every earlier write landed before that corner. No pixel is read after it has been overwritten, and no second frame buffer is needed.

Software, or a bus adapter, pulses a start line with the frame base address on a parallel input. It can later pulse a stop line to abandon the frame. The engine fetches the nine pixels of a window through a RAM port with one-cycle read latency. It runs them through a two-stage gradient pipeline (stage one forms both directional gradients, stage two forms the saturated magnitude) and interleaves each result write with the reads of the following window. Each window takes a ten-cycle slot: nine reads and one write.

Top module: `sobel_inplace_engine`

## Requirements
- R1: After reset, `busy`, `done` and `ram_en` are all low, and they stay low until a start command arrives.
- R2: A pulse on `cmd_start` while idle captures `cmd_base`. `busy` is high from the next cycle until the cycle after the final result write. A new frame can be started after a finished or stopped one.
- R3: Each result equals min(255, |Gx| + |Gy|). Take p1..p9 as the window pixels in row-major order, with p1 at the top-left. Then Gx = (p3 + 2·p6 + p9) − (p1 + 2·p4 + p7) and Gy = (p7 + 2·p8 + p9) − (p1 + 2·p2 + p3). All pixels are read from the frame as it was at start.
- R4: The result of the window at column x, row y is written to base + IMG_W·y + x, which is the address of its p1 pixel.
- R5: Exactly (IMG_W−2)·(IMG_H−2) results are written per frame. Pixels in the last two columns or last two rows of the frame are left unchanged, and so is every RAM location outside the frame.
- R6: Result writes occur in raster order, so each write address offset from the base is larger than the one before it.
- R7: The RAM sees at most one access per cycle, and no two result writes fall in consecutive cycles.
- R8: `done` is high for exactly one cycle, the cycle right after the final write. `busy` is already low in that cycle.
- R9: A pulse on `cmd_stop` during a frame suppresses every RAM write from that cycle on, returns the engine to idle within one ten-cycle slot, and produces no `done`. A stop while idle has no effect.
- R10: A `cmd_start` pulse while busy is ignored, and the frame continues at its original base address.
- R11: A magnitude above 255, such as a sharp 0-to-255 step edge, is written as 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse; accepted only while idle |
| cmd_stop | input | 1 | Abort pulse; acted on only while busy |
| cmd_base | input | ADDR_W | Frame base address, captured with start |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable (read when low) |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | PIX_W | Result pixel to write |
| ram_rdata | input | PIX_W | Read data, valid one cycle after a read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The bench builds the engine with a 6×5 frame and an 8-bit address. That gives twelve windows per frame, so complete frames, the skipped right and bottom margins, and the final-window drain all finish in a few hundred cycles. With an 8-bit address the whole 256-word RAM can be compared after every frame, including the frame placed flush against the top of the address space. The small geometry also puts the row wrap (the address jump by three) in every frame, several times over.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } eng_state_e;

    localparam int TAPS      = 9;
    localparam int SLOT_LEN  = 10;
    localparam int EXT_BITS  = 3;

endpackage

// File: rtl/sobel_addr_gen.sv
module sobel_addr_gen #(
    parameter int IMG_W  = 256,
    parameter int IMG_H  = 256,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] win_addr,
    output logic              last_win
);
    localparam int XW = $clog2(IMG_W);
    localparam int YW = $clog2(IMG_H);
    localparam logic [XW-1:0] X_LAST = XW'(IMG_W - 3);
    localparam logic [YW-1:0] Y_LAST = YW'(IMG_H - 3);
    localparam logic [ADDR_W-1:0] ROW_JUMP = ADDR_W'(3);

    typedef struct packed {
        logic [XW-1:0]     x;
        logic [YW-1:0]     y;
        logic [ADDR_W-1:0] addr;
    } ag_t;

    ag_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.x    = '0;
            nxt_d.y    = '0;
            nxt_d.addr = base;
        end else if (step) begin
            if (cur_q.x == X_LAST) begin
                nxt_d.x    = '0;
                nxt_d.y    = cur_q.y + YW'(1);
                nxt_d.addr = cur_q.addr + ROW_JUMP;
            end else begin
                nxt_d.x    = cur_q.x + XW'(1);
                nxt_d.addr = cur_q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign win_addr = cur_q.addr;
    assign last_win = (cur_q.x == X_LAST) && (cur_q.y == Y_LAST);

    // R5
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.x <= X_LAST) && (cur_q.y <= Y_LAST));

endmodule

// File: rtl/sobel_window.sv
module sobel_window #(
    parameter int PIX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  shift_last,
    input  logic [PIX_W-1:0]      din,
    output logic [8:0][PIX_W-1:0] win,
    output logic                  win_vld
);
    typedef struct packed {
        logic [8:0][PIX_W-1:0] taps;
        logic                  vld;
    } wn_t;

    wn_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = shift_en && shift_last;
        if (shift_en) begin
            nxt_d.taps = {din, cur_q.taps[8:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign win     = cur_q.taps;
    assign win_vld = cur_q.vld;

    // R7
    last_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_last |-> shift_en);

endmodule

// File: rtl/sobel_grad.sv
module sobel_grad #(
    parameter int PIX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [8:0][PIX_W-1:0] win,
    output logic                  out_vld,
    output logic [PIX_W-1:0]      out_pix
);
    localparam int GW = PIX_W + sobel_pkg::EXT_BITS;
    localparam logic [GW-1:0] MAXP = GW'((1 << PIX_W) - 1);

    typedef struct packed {
        logic [GW-1:0]    gx;
        logic [GW-1:0]    gy;
        logic             v1;
        logic [PIX_W-1:0] pix;
        logic             v2;
    } gr_t;

    gr_t cur_q, nxt_d;

    function automatic logic [GW-1:0] ext(input logic [PIX_W-1:0] p);
        return {{sobel_pkg::EXT_BITS{1'b0}}, p};
    endfunction

    logic [GW-1:0] ax, ay, mag;

    always_comb begin
        ax  = cur_q.gx[GW-1] ? (~cur_q.gx + GW'(1)) : cur_q.gx;
        ay  = cur_q.gy[GW-1] ? (~cur_q.gy + GW'(1)) : cur_q.gy;
        mag = ax + ay;
    end

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.v1 = in_vld;
        if (in_vld) begin
            nxt_d.gx = (ext(win[2]) + (ext(win[5]) << 1) + ext(win[8]))
                     - (ext(win[0]) + (ext(win[3]) << 1) + ext(win[6]));
            nxt_d.gy = (ext(win[6]) + (ext(win[7]) << 1) + ext(win[8]))
                     - (ext(win[0]) + (ext(win[1]) << 1) + ext(win[2]));
        end
        nxt_d.v2 = cur_q.v1;
        if (cur_q.v1) begin
            nxt_d.pix = (mag > MAXP) ? '1 : mag[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_vld = cur_q.v2;
    assign out_pix = cur_q.pix;

    logic flat;
    always_comb begin
        flat = 1'b1;
        for (int i = 1; i < 9; i++) begin
            if (win[i] != win[0]) flat = 1'b0;
        end
    end

    // R3
    flat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && flat) |=> ##1 (out_vld && (out_pix == '0)));

endmodule

// File: rtl/sobel_inplace_engine.sv
module sobel_inplace_engine #(
    parameter int IMG_W  = 256,
    parameter int IMG_H  = 256,
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [ADDR_W-1:0] cmd_base,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [PIX_W-1:0]  ram_wdata,
    input  logic [PIX_W-1:0]  ram_rdata,
    output logic              busy,
    output logic              done
);
    import sobel_pkg::*;

    localparam logic [3:0] SLOT_WR  = 4'(SLOT_LEN - 1);
    localparam logic [3:0] SLOT_LRD = 4'(SLOT_LEN - 2);
    localparam logic [ADDR_W-1:0] ROW1 = ADDR_W'(IMG_W);
    localparam logic [ADDR_W-1:0] ROW2 = ADDR_W'(2 * IMG_W);

    typedef struct packed {
        eng_state_e        state;
        logic [3:0]        slot;
        logic [1:0]        r;
        logic [1:0]        c;
        logic              have_prev;
        logic              stop_pend;
        logic [ADDR_W-1:0] prev_addr;
        logic              rd_vld;
        logic              rd_last;
        logic              done;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic [ADDR_W-1:0]     win_addr;
    logic                  last_win;
    logic                  ag_load, ag_step;
    logic [8:0][PIX_W-1:0] win;
    logic                  win_vld;
    logic                  res_vld;
    logic [PIX_W-1:0]      res_pix;

    logic              rd_now, wr_slot, stop_now, wr_now;
    logic [ADDR_W-1:0] row_off, rd_addr;

    always_comb begin
        rd_now   = (cur_q.state == ST_RUN) && (cur_q.slot < SLOT_WR);
        wr_slot  = (cur_q.state != ST_IDLE) && (cur_q.slot == SLOT_WR);
        stop_now = cur_q.stop_pend || cmd_stop;
        wr_now   = wr_slot && cur_q.have_prev && !stop_now;
        case (cur_q.r)
            2'd1:    row_off = ROW1;
            2'd2:    row_off = ROW2;
            default: row_off = '0;
        endcase
        rd_addr  = win_addr + row_off + ADDR_W'(cur_q.c);
        ag_load  = (cur_q.state == ST_IDLE) && cmd_start;
        ag_step  = (cur_q.state == ST_RUN) && (cur_q.slot == SLOT_WR)
                   && !stop_now && !last_win;
    end

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.done    = 1'b0;
        nxt_d.rd_vld  = rd_now;
        nxt_d.rd_last = rd_now && (cur_q.slot == SLOT_LRD);
        case (cur_q.state)
            ST_IDLE: begin
                if (cmd_start) begin
                    nxt_d.state     = ST_RUN;
                    nxt_d.slot      = '0;
                    nxt_d.r         = '0;
                    nxt_d.c         = '0;
                    nxt_d.have_prev = 1'b0;
                    nxt_d.stop_pend = 1'b0;
                end
            end
            default: begin
                if (cmd_stop) nxt_d.stop_pend = 1'b1;
                if (cur_q.slot == SLOT_WR) begin
                    nxt_d.slot = '0;
                    nxt_d.r    = '0;
                    nxt_d.c    = '0;
                    if (stop_now) begin
                        nxt_d.state = ST_IDLE;
                    end else if (cur_q.state == ST_DRAIN) begin
                        nxt_d.state = ST_IDLE;
                        nxt_d.done  = 1'b1;
                    end else begin
                        nxt_d.have_prev = 1'b1;
                        nxt_d.prev_addr = win_addr;
                        nxt_d.state     = last_win ? ST_DRAIN : ST_RUN;
                    end
                end else begin
                    nxt_d.slot = cur_q.slot + 4'd1;
                    if (cur_q.c == 2'd2) begin
                        nxt_d.c = '0;
                        nxt_d.r = cur_q.r + 2'd1;
                    end else begin
                        nxt_d.c = cur_q.c + 2'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    sobel_addr_gen #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ag_load),
        .base    (cmd_base),
        .step    (ag_step),
        .win_addr(win_addr),
        .last_win(last_win)
    );

    sobel_window #(.PIX_W(PIX_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cur_q.rd_vld),
        .shift_last(cur_q.rd_last),
        .din       (ram_rdata),
        .win       (win),
        .win_vld   (win_vld)
    );

    sobel_grad #(.PIX_W(PIX_W)) u_grad (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (win_vld),
        .win    (win),
        .out_vld(res_vld),
        .out_pix(res_pix)
    );

    assign ram_en    = rd_now || wr_now;
    assign ram_we    = wr_now;
    assign ram_addr  = wr_now ? cur_q.prev_addr : rd_addr;
    assign ram_wdata = res_pix;
    assign busy      = (cur_q.state != ST_IDLE);
    assign done      = cur_q.done;

    logic              chk_seen_q, chk_res_q;
    logic [ADDR_W-1:0] chk_base_q, chk_off_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_seen_q <= 1'b0;
            chk_res_q  <= 1'b0;
            chk_base_q <= '0;
            chk_off_q  <= '0;
        end else if (ag_load) begin
            chk_seen_q <= 1'b0;
            chk_res_q  <= 1'b0;
            chk_base_q <= cmd_base;
        end else begin
            if (res_vld) chk_res_q <= 1'b1;
            if (ram_we) begin
                chk_seen_q <= 1'b1;
                chk_off_q  <= ram_addr - chk_base_q;
            end
        end
    end

    // R6
    raster_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && chk_seen_q) |-> ((ram_addr - chk_base_q) > chk_off_q));

    // R3
    wr_has_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> chk_res_q);

    // R7
    wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_en);

endmodule

// File: tb/sobel_inplace_engine_tb.sv
module sobel_inplace_engine_tb;
    localparam int IW = 6;
    localparam int IH = 5;
    localparam int AW = 8;
    localparam int NWIN = (IW - 2) * (IH - 2);
    localparam int NVEC = 6;
    // base[23:16], pattern kind[15:8], seed[7:0]
    localparam logic [23:0] VECS [0:NVEC-1] = '{
        24'h000003, 24'h25005b, 24'hE2014D, 24'h640200, 24'h0A0300, 24'h9600C8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_stop = 1'b0;
    logic [AW-1:0] cmd_base = '0;
    logic ram_en, ram_we, busy, done;
    logic [AW-1:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata;

    always #5 clk = ~clk;

    sobel_inplace_engine #(.IMG_W(IW), .IMG_H(IH), .PIX_W(8), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_base(cmd_base), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .busy(busy), .done(done)
    );

    logic [7:0] mem [0:255];
    logic [7:0] ref_img [0:255];
    logic [7:0] exp_mem [0:255];
    logic [7:0] wr_log [0:63];
    int wr_cnt = 0, done_cnt = 0, gap_err = 0, cyc = 0;
    int last_wr_cyc = 0, done_cyc = 0;
    logic busy_at_done = 1'b0, prev_we = 1'b0;
    logic ld_en = 1'b0, clr = 1'b0;
    logic [7:0] ld_addr = '0, ld_data = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_we <= ram_en && ram_we;
        if (ld_en) mem[ld_addr] <= ld_data;
        if (clr) begin
            wr_cnt <= 0; done_cnt <= 0; gap_err <= 0;
        end else begin
            if (ram_en && ram_we) begin
                mem[ram_addr] <= ram_wdata;
                if (wr_cnt < 64) wr_log[wr_cnt] <= ram_addr;
                wr_cnt <= wr_cnt + 1;
                last_wr_cyc <= cyc;
                if (prev_we) gap_err <= gap_err + 1;
            end
            if (done) begin
                done_cnt <= done_cnt + 1;
                done_cyc <= cyc;
                busy_at_done <= busy;
            end
        end
        if (ram_en && !ram_we) ram_rdata <= mem[ram_addr];
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int kind, input int seed, input int i);
        case (kind)
            0: return 8'((i * 37 + seed * 11) ^ (i >> 2));
            1: return 8'(seed);
            2: return ((i % IW) < 3) ? 8'd0 : 8'd255;
            default: return (i % 2 == 1) ? 8'd255 : 8'd0;
        endcase
    endfunction

    task automatic load(input int kind, input int seed);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = pat(kind, seed, i);
            ref_img[i] = ld_data;
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic int sob(input int a);
        int p[9];
        int gx, gy, m;
        for (int k = 0; k < 9; k++) p[k] = int'(ref_img[(a + (k / 3) * IW + (k % 3)) & 255]);
        gx = (p[2] + 2 * p[5] + p[8]) - (p[0] + 2 * p[3] + p[6]);
        gy = (p[6] + 2 * p[7] + p[8]) - (p[0] + 2 * p[1] + p[2]);
        m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        return (m > 255) ? 255 : m;
    endfunction

    // nwr: number of leading windows expected to have been written
    task automatic expect_frame(input int base, input int nwr);
        int k;
        for (int i = 0; i < 256; i++) exp_mem[i] = ref_img[i];
        k = 0;
        for (int y = 0; y < IH - 2; y++)
            for (int x = 0; x < IW - 2; x++) begin
                if (k < nwr) exp_mem[(base + IW * y + x) & 255] = 8'(sob(base + IW * y + x));
                k++;
            end
    endtask

    task automatic compare_mem(input string req);
        for (int i = 0; i < 256; i++)
            check(mem[i] == exp_mem[i], req, int'(mem[i]), int'(exp_mem[i]));
    endtask

    task automatic clear_log();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic run_frame(input int base, input bit restart_mid);
        int n;
        clear_log();
        cmd_base = 8'(base); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (restart_mid) begin
            repeat (25) @(negedge clk);
            cmd_base = 8'(base + 50); cmd_start = 1'b1;
            @(negedge clk); cmd_start = 1'b0; cmd_base = 8'(base);
            check(busy == 1'b1, "R10 busy kept", int'(busy), 1);
        end
        n = 0;
        while (done_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R8 done pulses", done_cnt, 1);
        check(done_cyc == last_wr_cyc + 1, "R8 done timing", done_cyc, last_wr_cyc + 1);
        check(busy_at_done == 1'b0, "R8 busy low at done", int'(busy_at_done), 0);
        check(wr_cnt == NWIN, "R5 write count", wr_cnt, NWIN);
        check(gap_err == 0, "R7 write spacing", gap_err, 0);
        for (int y = 0; y < IH - 2; y++)
            for (int x = 0; x < IW - 2; x++)
                check(wr_log[y * (IW - 2) + x] == 8'(base + IW * y + x),
                      restart_mid ? "R10 write addr" : "R4 R6 write addr",
                      int'(wr_log[y * (IW - 2) + x]), (base + IW * y + x) & 255);
        expect_frame(base, NWIN);
        compare_mem("R3 R5 R11 memory");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int snap;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(ram_en == 1'b0, "R1 ram_en", int'(ram_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && ram_en == 1'b0, "R1 idle after reset", int'(busy), 0);

        for (int v = 0; v < NVEC; v++) begin
            load(int'(VECS[v][15:8]), int'(VECS[v][7:0]));
            run_frame(int'(VECS[v][23:16]), 1'b0);
        end

        // R11 step edge saturates
        load(2, 0);
        run_frame(0, 1'b0);
        check(mem[1] == 8'd255, "R11 saturation", int'(mem[1]), 255);

        // R10 start while busy ignored
        load(0, 17);
        run_frame(40, 1'b1);

        // R9 stop while idle does nothing
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
        check(busy == 1'b0 && ram_en == 1'b0, "R9 idle stop", int'(busy), 0);

        // R9 stop mid-frame
        load(0, 123);
        clear_log();
        cmd_base = 8'd20; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        n = 0;
        while (wr_cnt < 3 && n < 2000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        snap = wr_cnt;
        cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
        repeat (12) @(negedge clk);
        check(busy == 1'b0, "R9 busy after stop", int'(busy), 0);
        check(wr_cnt == snap, "R9 no write after stop", wr_cnt, snap);
        check(done_cnt == 0, "R9 no done", done_cnt, 0);
        expect_frame(20, snap);
        compare_mem("R9 memory after stop");

        // R2 restart after stop
        load(3, 0);
        run_frame(60, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule